// File: doc/BRIEF.md
# Boundary-Scan Test Port for Tristate Pins

This block is a serial test port that lets a board tester take over a device's bidirectional pins. Four serial signals carry everything: a test clock, a mode select, serial data in and serial data out. A sixteen-state controller, stepped only by the mode-select level seen at each rising test-clock edge, sequences capture, shift and update phases for either an instruction register or a data register.

Every tristate pin owns a group of three boundary cells: an enable cell that turns the pad driver on, a value cell that gives the level to drive, and a sense cell that records the pad level. In normal operation the core logic drives the pads directly and the boundary cells only observe. A sample/preload scan loads the cells without touching the pads. An external-test instruction then hands the pads to the update latches, so one device can drive a board net while a second device samples it. Instructions outside the three supported ones select the one-bit bypass path.

Top module: `bscan_port`

Controller states: RESET, IDLE, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR, SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR. The first name after each state is its successor for mode select 1, the second for mode select 0: RESET (RESET/IDLE), IDLE (SEL_DR/IDLE), SEL_DR (SEL_IR/CAP_DR), CAP_DR (EX1_DR/SH_DR), SH_DR (EX1_DR/SH_DR), EX1_DR (UPD_DR/PAU_DR), PAU_DR (EX2_DR/PAU_DR), EX2_DR (UPD_DR/SH_DR), UPD_DR (SEL_DR/IDLE), SEL_IR (RESET/CAP_IR), and the IR branch mirrors the DR branch, with UPD_IR going to SEL_DR or IDLE.

## Requirements
- R1: The controller state changes only at the rising edge of tck and depends only on tms; five consecutive tms=1 clocks reach RESET from any state, and RESET ends external test so that the pads follow core_dout/core_den again.
- R2: From RESET, the tms sequence 0,1,0,0,1,0 leaves the controller in PAU_DR, where tms=0 holds it; tms 1 then 0 returns it to SH_DR.
- R3: The instruction register is IR_W bits wide (default 2). Capture loads the value 1 (binary 01), shifting moves bits toward tdo LSB first, and a new code takes effect at the UPD_IR edge. Codes: all zeros = external test, 1 = sample/preload, all ones = bypass, and any other code acts as bypass. RESET loads the bypass code.
- R4: With bypass selected the data path is one bit long; it captures 0 and presents each tdi bit at tdo one shift later.
- R5: The boundary register holds 3*NPIN cells; for pin i, cell 3i is the sense cell, 3i+1 the value cell and 3i+2 the enable cell, and cell 0 is nearest tdo. A capture loads pad_in into sense cells, core_dout into value cells and core_den into enable cells.
- R6: Outside external test, pad_out equals core_dout and pad_oe equals core_den at all times, including while a sample/preload scan shifts; core_din always equals pad_in.
- R7: Under external test, pad_oe follows the enable latch (1 drives, 0 leaves the pad undriven) and pad_out follows the value latch, and sense cells capture the level another device drives onto the net.
- R8: The boundary update latches change only at the UPD_DR edge (and are cleared in RESET); shifting a new vector during external test leaves the pads unchanged until that edge.
- R9: tdo changes only at the falling edge of tck; tdo_oe is 1 only while the controller is in SH_IR or SH_DR, and tdo holds its last value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low power-on reset, forces RESET |
| tms | input | 1 | Mode select, sampled at rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated at falling tck |
| tdo_oe | output | 1 | High while tdo carries valid shift data |
| core_dout | input | NPIN | Value the core wants on each pad |
| core_den | input | NPIN | Core driver enable for each pad |
| core_din | output | NPIN | Pad level returned to the core |
| pad_out | output | NPIN | Value driven toward each pad |
| pad_oe | output | NPIN | Pad driver enable |
| pad_in | input | NPIN | Level observed on each pad |

## Verification
The assertions watch every cycle that the controller stays in RESET under tms=1 and moves from EX1_DR to PAU_DR under tms=0, that the instruction and update latches only move at their update or reset states, and that tdo is only enabled in the two shift states and is otherwise held at each falling edge. What only the scenarios can show is the end-to-end board behaviour: two ports sharing tms and a wired net, one preloaded to drive a level, the other's sense cell reading it back after external test, plus the serial contents of the bypass and instruction captures and the stability of the pads during scans.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_t;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_t nxt;

    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_dr   = (state == ST_CAP_DR);
        sh_dr    = (state == ST_SH_DR);
        upd_dr   = (state == ST_UPD_DR);
        cap_ir   = (state == ST_CAP_IR);
        sh_ir    = (state == ST_SH_IR);
        upd_ir   = (state == ST_UPD_IR);
    end

    // R1: tms held high keeps the controller in reset
    p_reset_sticky_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    // R2: leaving the first exit with tms low parks in pause
    p_exit_to_pause_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_EX1_DR && !tms) |=> (state == ST_PAU_DR));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir #(
    parameter int                IR_W     = 2,
    parameter logic [IR_W-1:0]   RST_CODE = '1
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    output logic            so,
    output logic [IR_W-1:0] ir_q
);

    localparam logic [IR_W-1:0] CAP_CODE = IR_W'(1);

    logic [IR_W-1:0] sr;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)     sr <= CAP_CODE;
        else if (cap)   sr <= CAP_CODE;
        else if (shift) sr <= {tdi, sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)        ir_q <= RST_CODE;
        else if (in_reset) ir_q <= RST_CODE;
        else if (upd)      ir_q <= sr;
    end

    assign so = sr[0];

    // R3: the active instruction moves only on update or reset
    p_ir_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
        !(upd || in_reset) |=> $stable(ir_q));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int NPIN = 2
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    input  logic            extest,
    input  logic [NPIN-1:0] core_dout,
    input  logic [NPIN-1:0] core_den,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            so
);

    localparam int LEN = 3 * NPIN;

    logic [LEN-1:0] sr;
    logic [LEN-1:0] upd_q;
    logic [LEN-1:0] cap_vec;

    // Per pin: sense cell, then value cell, then enable cell
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign cap_vec[3*g +: 3] = {core_den[g], core_dout[g], pad_in[g]};
        assign pad_out[g] = extest ? upd_q[3*g+1] : core_dout[g];
        assign pad_oe[g]  = extest ? upd_q[3*g+2] : core_den[g];
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (cap)   sr <= cap_vec;
        else if (shift) sr <= {tdi, sr[LEN-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)        upd_q <= '0;
        else if (in_reset) upd_q <= '0;
        else if (upd)      upd_q <= sr;
    end

    assign so = sr[0];

    // R8: update latches hold except on the update edge or in reset
    p_latch_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
        !(upd || in_reset) |=> $stable(upd_q));

endmodule

// File: rtl/bscan_port.sv
module bscan_port
    import bscan_pkg::*;
#(
    parameter int NPIN = 2,
    parameter int IR_W = 2
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [NPIN-1:0] core_dout,
    input  logic [NPIN-1:0] core_den,
    output logic [NPIN-1:0] core_din,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    input  logic [NPIN-1:0] pad_in
);

    localparam logic [IR_W-1:0] OP_EXTEST = '0;
    localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);
    localparam logic [IR_W-1:0] OP_BYPASS = '1;

    tap_state_t      state;
    logic            in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, bsr_so, byp_q;
    logic            bsr_sel, extest;

    bscan_fsm u_fsm (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
    );

    bscan_ir #(.IR_W(IR_W), .RST_CODE(OP_BYPASS)) u_ir (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .in_reset(in_reset),
        .cap(cap_ir), .shift(sh_ir), .upd(upd_ir), .so(ir_so), .ir_q(ir_q)
    );

    assign extest  = (ir_q == OP_EXTEST);
    assign bsr_sel = extest || (ir_q == OP_SAMPLE);

    bscan_chain #(.NPIN(NPIN)) u_chain (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .in_reset(in_reset),
        .cap(cap_dr && bsr_sel), .shift(sh_dr && bsr_sel), .upd(upd_dr && bsr_sel),
        .extest(extest), .core_dout(core_dout), .core_den(core_den),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .so(bsr_so)
    );

    assign core_din = pad_in;

    // One-bit bypass path for every code that is not a boundary access
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                 byp_q <= 1'b0;
        else if (cap_dr && !bsr_sel) byp_q <= 1'b0;
        else if (sh_dr && !bsr_sel)  byp_q <= tdi;
    end

    // Serial output launched on the falling edge, held outside shifts
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (sh_ir) begin
            tdo    <= ir_so;
            tdo_oe <= 1'b1;
        end else if (sh_dr) begin
            tdo    <= bsr_sel ? bsr_so : byp_q;
            tdo_oe <= 1'b1;
        end else begin
            tdo_oe <= 1'b0;
        end
    end

    // R9: output enable only observed inside a shift state
    p_tdo_window_r9: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

    // R9: outside shift states tdo keeps its value across falling edges
    p_tdo_held_r9: assert property (@(negedge tck) disable iff (!rst_n)
        !(state == ST_SH_DR || state == ST_SH_IR) |=> $stable(tdo));

endmodule

// File: tb/bscan_port_bench.sv
`timescale 1ns/1ps
module bscan_port_bench;

    localparam int NPIN = 2;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi_a = 1'b0, tdi_b = 1'b0;
    logic tdo_a, tdo_b, oe_a, oe_b;
    logic [NPIN-1:0] cdout_a = 2'b10, cden_a = 2'b00;
    logic [NPIN-1:0] cdout_b = 2'b00, cden_b = 2'b00;
    logic [NPIN-1:0] din_a, din_b, pout_a, pout_b, poe_a, poe_b;
    logic [NPIN-1:0] net;

    int n_chk = 0;
    int n_err = 0;
    int rise_glitch = 0;

    always #2.5 tck = ~tck;

    // Board net: each pin wired between the two devices, weak pull-down
    for (genvar g = 0; g < NPIN; g++) begin : g_net
        assign net[g] = poe_a[g] ? pout_a[g] : (poe_b[g] ? pout_b[g] : 1'b0);
    end

    bscan_port u_bscan_port (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi_a), .tdo(tdo_a), .tdo_oe(oe_a),
        .core_dout(cdout_a), .core_den(cden_a), .core_din(din_a),
        .pad_out(pout_a), .pad_oe(poe_a), .pad_in(net)
    );

    bscan_port u_peer (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi_b), .tdo(tdo_b), .tdo_oe(oe_b),
        .core_dout(cdout_b), .core_den(cden_b), .core_din(din_b),
        .pad_out(pout_b), .pad_oe(poe_b), .pad_in(net)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One tck cycle: drive after the falling edge, read tdo before the rising edge
    task automatic step(input logic m, input logic da, input logic db,
                        output logic qa, output logic qb);
        @(negedge tck);
        tms = m; tdi_a = da; tdi_b = db;
        #1;
        qa = tdo_a; qb = tdo_b;
        @(posedge tck);
        #1;
        if (tdo_a !== qa) rise_glitch++;
    endtask

    task automatic idle(input logic m);
        logic qa, qb;
        step(m, 1'b0, 1'b0, qa, qb);
    endtask

    // DR scan from IDLE back to IDLE; stable=1 if pin0 of device A never moved before update
    task automatic scan_dr(input logic [5:0] va, input logic [5:0] vb, input int n,
                           output logic [5:0] oa, output logic [5:0] ob, output logic stable);
        logic qa, qb, oe0, o0;
        oa = '0; ob = '0;
        idle(1'b1); idle(1'b0); idle(1'b0);
        oe0 = poe_a[0]; o0 = pout_a[0]; stable = 1'b1;
        for (int k = 0; k < n; k++) begin
            step(k == n - 1, va[k], vb[k], qa, qb);
            oa[k] = qa; ob[k] = qb;
            if (poe_a[0] !== oe0 || pout_a[0] !== o0) stable = 1'b0;
        end
        idle(1'b1); idle(1'b0);
    endtask

    task automatic scan_ir(input logic [1:0] va, input logic [1:0] vb,
                           output logic [1:0] oa, output logic [1:0] ob);
        logic qa, qb;
        idle(1'b1); idle(1'b1); idle(1'b0); idle(1'b0);
        for (int k = 0; k < 2; k++) begin
            step(k == 1, va[k], vb[k], qa, qb);
            oa[k] = qa; ob[k] = qb;
        end
        idle(1'b1); idle(1'b0);
    endtask

    task automatic t_reset;
        check("R9", "tdo_oe after reset", oe_a, 0);
        check("R6", "pad_out follows core", pout_a, cdout_a);
        check("R6", "pad_oe follows core", poe_a, cden_a);
        check("R6", "core_din follows pad", din_a, net);
    endtask

    task automatic t_bypass;
        logic [5:0] oa, ob; logic st;
        scan_dr(6'b001101, 6'b000000, 4, oa, ob, st);
        check("R4", "bypass stream", oa[3:0], 4'b1010);
        check("R9", "tdo steady at rising edge", rise_glitch, 0);
    endtask

    task automatic t_ir_capture;
        logic [1:0] oa, ob;
        scan_ir(2'b01, 2'b01, oa, ob);
        check("R3", "instruction capture pattern", oa, 2'b01);
    endtask

    task automatic t_sample;
        logic [5:0] oa, ob; logic st;
        scan_dr(6'b000110, 6'b000000, 6, oa, ob, st);
        check("R5", "boundary capture of A", oa, 6'b010000);
        check("R6", "pads unmoved during preload", st, 1);
        check("R6", "pad_oe still core after preload", poe_a, cden_a);
    endtask

    task automatic t_extest;
        logic [1:0] ia, ib; logic [5:0] oa, ob; logic st;
        scan_ir(2'b00, 2'b00, ia, ib);
        check("R7", "A drives pin0 enable", poe_a[0], 1);
        check("R7", "A drives pin0 value", pout_a[0], 1);
        check("R7", "B pin0 undriven", poe_b[0], 0);
        scan_dr(6'b000110, 6'b000000, 6, oa, ob, st);
        check("R7", "B sense cell sees 1", ob[0], 1);
        check("R7", "A sense cell sees 1", oa[0], 1);
        check("R7", "B pin1 sense sees 0", ob[3], 0);
    endtask

    task automatic t_update_only;
        logic [5:0] oa, ob; logic st;
        scan_dr(6'b000010, 6'b000000, 6, oa, ob, st);
        check("R8", "pads held while shifting", st, 1);
        check("R8", "enable released after update", poe_a[0], 0);
        scan_dr(6'b000110, 6'b000000, 6, oa, ob, st);
        check("R7", "B sense sees released net 0", ob[0], 0);
        check("R8", "enable set again after update", poe_a[0], 1);
    endtask

    task automatic t_five_ones;
        logic [5:0] oa, ob; logic st;
        idle(1'b1); idle(1'b0); idle(1'b0);
        for (int k = 0; k < 5; k++) idle(1'b1);
        check("R1", "reset ends external test", poe_a[0], cden_a[0]);
        idle(1'b0);
        scan_dr(6'b000011, 6'b000000, 2, oa, ob, st);
        check("R3", "reset selects bypass", oa[1:0], 2'b10);
    endtask

    task automatic t_pause;
        logic qa, qb;
        idle(1'b0);
        for (int k = 0; k < 5; k++) idle(1'b1);
        idle(1'b0); idle(1'b1); idle(1'b0); idle(1'b0); idle(1'b1); idle(1'b0);
        step(1'b0, 1'b0, 1'b0, qa, qb);
        check("R2", "pause keeps tdo disabled", oe_a, 0);
        idle(1'b1);
        step(1'b0, 1'b1, 1'b0, qa, qb);
        step(1'b1, 1'b0, 1'b0, qa, qb);
        check("R2", "back in shift after exit2", oe_a, 1);
        idle(1'b1); idle(1'b0);
        #3;
        check("R9", "tdo disabled in idle", oe_a, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge tck);
        @(negedge tck);
        rst_n = 1'b1;
        idle(1'b0);
        t_reset();
        t_bypass();
        t_ir_capture();
        t_sample();
        t_extest();
        t_update_only();
        t_five_ones();
        t_pause();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule